// File: doc/BRIEF.md
# Delayed Sleep Output Sequencer

This block drives two independent active-high sleep-control outputs, X and Y, from a single active-low suspend-acknowledge input. When suspend-acknowledge is sampled low, each channel starts counting edges of the slow clock. Its output rises once the count reaches that channel's programmed delay. The output stays high until suspend-acknowledge returns high, and then both outputs drop and both counters clear.

Three 32-bit registers are reached through a simple synchronous port: one configuration word per channel and one shared sleep-clock delay word. Each channel word holds an enable bit and a 30-bit delay.

A channel whose delay exceeds the sleep-clock delay is held off for the whole suspend period, but only while the sleep-clock enable is set. The enable bit, the delay and this inhibit decision are captured when a count starts, so register writes made during a suspend period only affect the next one. Everything runs on the slow clock.

Top module: `sleep_seq_top`

## Requirements
- R1: After reset, all three registers read 00000000h, `reg_rdata` is zero, and both sleep outputs are low.
- R2: The X channel word is at offset 04h, the Y channel word at 08h and the sleep-clock word at 10h. Each read returns all 32 bits last written, on `reg_rdata`, one cycle after the address is presented. A write in the same cycle as the read is not yet visible.
- R3: A read of any other offset returns zero.
- R4: Bit 30 of a channel word is the channel enable. When it is 0 at the start of a count, the channel output never rises during that suspend period.
- R5: The count starts at the first rising edge where `susp_ack_n` is sampled low. The output rises at edge number delay+1 after that start edge, where delay is bits 29:0 of the channel word, so a delay of 0 rises on the next edge. The output stays high while `susp_ack_n` remains low.
- R6: At any edge where `susp_ack_n` is sampled high, both outputs go low and both counts clear.
- R7: When bit 30 of the sleep-clock word is 1 and a channel delay is strictly greater than bits 29:0 of the sleep-clock word, that channel never rises. An equal delay still rises.
- R8: When bit 30 of the sleep-clock word is 0, the delay comparison is ignored.
- R9: Bit 31 of every register is stored and read back, but has no effect on output timing.
- R10: The enable, the delay and the inhibit decision are captured at the start edge. Writes made during a count take effect only at the next suspend-acknowledge assertion.
- R11: The two channels count and assert independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| susp_ack_n | input | 1 | Active-low suspend acknowledge |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| sleep_x | output | 1 | Sleep output X, active high |
| sleep_y | output | 1 | Sleep output Y, active high |

## Verification
The bench targets the inhibit comparison at its boundary: a delay equal to the sleep-clock delay and a delay one above it. A design using the wrong comparison would either suppress the equal case or let the larger one through.

It shortens a delay while a count is running. A design that did not capture the configuration at the start edge would raise the output early.

It runs a zero delay and sets bit 31 to catch off-by-one timing and a reserved bit that leaks into behaviour. It also releases suspend-acknowledge mid-count, which exposes a counter that survives into the next period.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
    localparam int CFG_W   = 32;
    localparam int DLY_W   = 30;
    localparam int EN_BIT  = 30;
    localparam int ADDR_W  = 8;
    localparam int NUM_CH  = 2;
    localparam logic [ADDR_W-1:0] OFF_CH0    = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_STRIDE = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_SCLK   = 8'h10;

    function automatic logic [ADDR_W-1:0] chan_offset(input int idx);
        return OFF_CH0 + OFF_STRIDE * ADDR_W'(idx);
    endfunction

    function automatic logic addr_mapped(input logic [ADDR_W-1:0] a);
        logic hit;
        hit = (a == OFF_SCLK);
        for (int i = 0; i < NUM_CH; i++) begin
            if (a == chan_offset(i)) hit = 1'b1;
        end
        return hit;
    endfunction

    // Channel is held off when the sleep-clock enable is set and its delay is larger.
    function automatic logic delay_blocked(input logic [EN_BIT:0] chan_w,
                                           input logic [EN_BIT:0] sclk_w);
        return sclk_w[EN_BIT] && (chan_w[DLY_W-1:0] > sclk_w[DLY_W-1:0]);
    endfunction

    typedef struct packed {
        logic             active;
        logic             armed;
        logic             out;
        logic [DLY_W-1:0] cnt;
        logic [DLY_W-1:0] dly;
    } chan_state_t;

    typedef struct packed {
        logic [NUM_CH-1:0][CFG_W-1:0] chan;
        logic [CFG_W-1:0]             sclk;
        logic [CFG_W-1:0]             rd;
    } reg_state_t;
endpackage

// File: rtl/sleep_regfile.sv
module sleep_regfile
    import sleep_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic                          reg_we,
    input  logic [CFG_W-1:0]              reg_wdata,
    output logic [CFG_W-1:0]              reg_rdata,
    output logic [NUM_CH-1:0][CFG_W-1:0]  chan_cfg,
    output logic [CFG_W-1:0]              sclk_cfg
);
    reg_state_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        // Read mux uses the pre-write contents.
        rf_d.rd = '0;
        if (reg_addr == OFF_SCLK) rf_d.rd = rf_q.sclk;
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_addr == chan_offset(i)) rf_d.rd = rf_q.chan[i];
        end
        if (reg_we) begin
            if (reg_addr == OFF_SCLK) rf_d.sclk = reg_wdata;
            for (int i = 0; i < NUM_CH; i++) begin
                if (reg_addr == chan_offset(i)) rf_d.chan[i] = reg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign reg_rdata = rf_q.rd;
    assign chan_cfg  = rf_q.chan;
    assign sclk_cfg  = rf_q.sclk;

    a_r2_sclk_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFF_SCLK) |=> (sclk_cfg == $past(reg_wdata)));

    a_r2_x_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFF_CH0) |=> (chan_cfg[0] == $past(reg_wdata)));

    a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_mapped(reg_addr) |=> (reg_rdata == '0));
endmodule

// File: rtl/sleep_chan.sv
module sleep_chan
    import sleep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              susp_ack_n,
    input  logic [EN_BIT:0]   chan_w,
    input  logic [EN_BIT:0]   sclk_w,
    output logic              sleep_o
);
    chan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (susp_ack_n) begin
            st_d = '0;
        end else if (!st_q.active) begin
            // Start edge: capture everything that governs this period.
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.out    = 1'b0;
            st_d.dly    = chan_w[DLY_W-1:0];
            st_d.armed  = chan_w[EN_BIT] && !delay_blocked(chan_w, sclk_w);
        end else begin
            if (st_q.armed && st_q.cnt == st_q.dly) st_d.out = 1'b1;
            if (st_q.cnt != st_q.dly) st_d.cnt = st_q.cnt + DLY_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sleep_o = st_q.out;

    a_r6_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        susp_ack_n |=> (!sleep_o && st_q.cnt == '0));

    a_r5_output_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && !susp_ack_n) |=> sleep_o);

    a_r7_unarmed_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !st_q.armed) |-> !sleep_o);

    a_r10_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !susp_ack_n) |=> ($stable(st_q.dly) && $stable(st_q.armed)));
endmodule

// File: rtl/sleep_seq_top.sv
module sleep_seq_top
    import sleep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              susp_ack_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [CFG_W-1:0]  reg_wdata,
    output logic [CFG_W-1:0]  reg_rdata,
    output logic              sleep_x,
    output logic              sleep_y
);
    logic [NUM_CH-1:0][CFG_W-1:0] chan_cfg;
    logic [CFG_W-1:0]             sclk_cfg;
    logic [NUM_CH-1:0]            sleep_vec;

    sleep_regfile i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .chan_cfg  (chan_cfg),
        .sclk_cfg  (sclk_cfg)
    );

    // Bit 31 of each word is storage only (R9); channels see bits 30:0.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        sleep_chan i_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .susp_ack_n (susp_ack_n),
            .chan_w     (chan_cfg[g][EN_BIT:0]),
            .sclk_w     (sclk_cfg[EN_BIT:0]),
            .sleep_o    (sleep_vec[g])
        );
    end

    assign sleep_x = sleep_vec[0];
    assign sleep_y = sleep_vec[1];

    a_r4_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(susp_ack_n) && !chan_cfg[0][EN_BIT]) |=> !sleep_x);
endmodule

// File: tb/test_sleep_seq_top.sv
module test_sleep_seq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        susp_ack_n = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sleep_x, sleep_y;

    int n_chk = 0;
    int n_fail = 0;
    bit checking = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    sleep_seq_top i_sleep_seq_top (
        .clk(clk), .rst_n(rst_n), .susp_ack_n(susp_ack_n),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sleep_x(sleep_x), .sleep_y(sleep_y)
    );

    // Behavioural reference model
    logic [31:0] m_cfg [2];
    logic [31:0] m_sc = '0;
    logic [31:0] m_rd = '0;
    bit          m_act [2];
    bit          m_arm [2];
    bit          m_out [2];
    int          m_cnt [2];
    int          m_dly [2];

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_cfg[c] = '0; m_act[c] = 0; m_arm[c] = 0;
            m_out[c] = 0; m_cnt[c] = 0; m_dly[c] = 0;
        end
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sc = '0; m_rd = '0;
            for (int c = 0; c < 2; c++) begin
                m_cfg[c] = '0; m_act[c] = 0; m_arm[c] = 0;
                m_out[c] = 0; m_cnt[c] = 0; m_dly[c] = 0;
            end
        end else begin
            case (reg_addr)
                8'h04:   m_rd = m_cfg[0];
                8'h08:   m_rd = m_cfg[1];
                8'h10:   m_rd = m_sc;
                default: m_rd = '0;
            endcase
            for (int c = 0; c < 2; c++) begin
                if (susp_ack_n) begin
                    m_act[c] = 0; m_cnt[c] = 0; m_out[c] = 0;
                end else if (!m_act[c]) begin
                    m_act[c] = 1; m_cnt[c] = 0; m_out[c] = 0;
                    m_dly[c] = int'(m_cfg[c][29:0]);
                    m_arm[c] = m_cfg[c][30] &&
                               !(m_sc[30] && (m_cfg[c][29:0] > m_sc[29:0]));
                end else begin
                    if (m_arm[c] && m_cnt[c] == m_dly[c]) m_out[c] = 1;
                    if (m_cnt[c] < m_dly[c]) m_cnt[c]++;
                end
            end
            if (reg_we) begin
                case (reg_addr)
                    8'h04: m_cfg[0] = reg_wdata;
                    8'h08: m_cfg[1] = reg_wdata;
                    8'h10: m_sc = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (checking) begin
            chk(cur_req, "rdata", reg_rdata, m_rd);
            chk(cur_req, "sleep_x", {31'b0, sleep_x}, {31'b0, m_out[0]});
            chk(cur_req, "sleep_y", {31'b0, sleep_y}, {31'b0, m_out[1]});
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        @(negedge clk);
        #1 chk(req, "readback", reg_rdata, exp);
    endtask

    task automatic suspend(input int n);
        susp_ack_n = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic release_susp();
        susp_ack_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 chk("R1", "reset rdata", reg_rdata, 32'h0);
        chk("R1", "reset sleep_x", {31'b0, sleep_x}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        checking = 1;
        rd_chk("R1", 8'h04, 32'h0);
        rd_chk("R1", 8'h10, 32'h0);

        cur_req = "R2";
        wr(8'h04, 32'h4000_0003);
        wr(8'h08, 32'h4000_0000);
        rd_chk("R2", 8'h04, 32'h4000_0003);
        rd_chk("R2", 8'h08, 32'h4000_0000);
        cur_req = "R3";
        rd_chk("R3", 8'h0C, 32'h0);
        rd_chk("R3", 8'h00, 32'h0);
        rd_chk("R3", 8'h14, 32'h0);

        // Zero delay on Y rises at the second edge; X (delay 3) at the fifth.
        cur_req = "R5";
        susp_ack_n = 1'b0;
        @(negedge clk);
        #1 chk("R5", "y before delay0 edge", {31'b0, sleep_y}, 32'h0);
        @(negedge clk);
        #1 chk("R5", "y delay0", {31'b0, sleep_y}, 32'h1);
        chk("R11", "x independent", {31'b0, sleep_x}, 32'h0);
        repeat (3) @(negedge clk);
        #1 chk("R5", "x after delay3", {31'b0, sleep_x}, 32'h1);
        repeat (4) @(negedge clk);
        cur_req = "R6";
        susp_ack_n = 1'b1;
        @(negedge clk);
        #1 chk("R6", "x cleared", {31'b0, sleep_x}, 32'h0);
        chk("R6", "y cleared", {31'b0, sleep_y}, 32'h0);

        // Release mid-count, then restart: count must begin from zero.
        susp_ack_n = 1'b0;
        repeat (3) @(negedge clk);
        susp_ack_n = 1'b1;
        @(negedge clk);
        susp_ack_n = 1'b0;
        repeat (3) @(negedge clk);
        #1 chk("R6", "x restart from zero", {31'b0, sleep_x}, 32'h0);
        release_susp();

        cur_req = "R4";
        wr(8'h04, 32'h0000_0002);
        suspend(8);
        #1 chk("R4", "disabled x", {31'b0, sleep_x}, 32'h0);
        release_susp();

        cur_req = "R7";
        wr(8'h10, 32'h4000_0005);
        wr(8'h04, 32'h4000_0006);
        wr(8'h08, 32'h4000_0005);
        suspend(12);
        #1 chk("R7", "x delay above sclk", {31'b0, sleep_x}, 32'h0);
        chk("R7", "y delay equal sclk", {31'b0, sleep_y}, 32'h1);
        release_susp();

        cur_req = "R8";
        wr(8'h10, 32'h0000_0005);
        wr(8'h04, 32'h4000_0009);
        suspend(13);
        #1 chk("R8", "x compare ignored", {31'b0, sleep_x}, 32'h1);
        release_susp();

        cur_req = "R9";
        wr(8'h04, 32'hC000_0002);
        wr(8'h08, 32'h4000_0002);
        wr(8'h10, 32'h8000_0000);
        rd_chk("R9", 8'h04, 32'hC000_0002);
        rd_chk("R9", 8'h10, 32'h8000_0000);
        susp_ack_n = 1'b0;
        repeat (4) @(negedge clk);
        #1 chk("R9", "x same as y", {31'b0, sleep_x}, {31'b0, sleep_y});
        chk("R9", "x up", {31'b0, sleep_x}, 32'h1);
        release_susp();

        cur_req = "R10";
        wr(8'h04, 32'h4000_0008);
        susp_ack_n = 1'b0;
        repeat (2) @(negedge clk);
        wr(8'h04, 32'h4000_0001);
        wr(8'h08, 32'h0000_0000);
        @(negedge clk);
        #1 chk("R10", "x not shortened", {31'b0, sleep_x}, 32'h0);
        chk("R10", "y keeps captured enable", {31'b0, sleep_y}, 32'h1);
        repeat (7) @(negedge clk);
        #1 chk("R10", "x at captured delay", {31'b0, sleep_x}, 32'h1);
        release_susp();
        susp_ack_n = 1'b0;
        repeat (3) @(negedge clk);
        #1 chk("R10", "new x delay", {31'b0, sleep_x}, 32'h1);
        chk("R10", "new y disable", {31'b0, sleep_y}, 32'h0);
        release_susp();

        checking = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule